// File: doc/BRIEF.md
# NAND Flash Memory-Mapped Host Port

This block is a bus slave that turns byte accesses on a plain memory-mapped bus into timed cycles on an 8-bit raw NAND flash bus. Most of the address space is a data window. Every write into it sends one byte to the flash with a write-strobe pulse. Every read from it fetches one byte with a read-strobe pulse. The low address bits inside the window do not matter, so a block copy over consecutive addresses streams bytes to or from the flash.

A small register window sits above the data window. Even addresses in it reach a control register that holds the chip-enable, command-latch and address-latch levels. Odd addresses reach a byte port that pushes command or address bytes; whether a byte is a command or an address depends on the latch levels already in the control register. A status register reports the synchronized flash ready line, a busy flag for the cycle engine, and a sticky flag that a command has finished. Chip enable is stored inverted: the host writes 0 to select the flash. Software polls the busy flag before each flash access. A data-window read holds back its bus response until the byte has been sampled. Each data-window byte is also offered on a one-cycle tap for a separate ECC block.

Top module: `nand_mmio_host`

## Requirements
- R1: After reset, the chip-enable output is high (deselected). The latch outputs are low, both strobes are high and the output enable is low. A read of the control register returns 0x01.
- R2: A write to any even offset from 0x800 to 0x80E stores bits 4:0 in the control register. Bit 0 drives the chip-enable output directly (1 = deselected). Bit 1 drives CLE and bit 2 drives ALE. Bits 3 and 4 are stored only. A read from any even offset in that range returns the stored value.
- R3: A write to any odd offset from 0x801 to 0x80F puts the write data on the flash I/O lines for one write-strobe pulse. CLE and ALE keep the levels set in the control register. The byte stays stable while the strobe is low.
- R4: Each flash cycle runs SETUP_CYC clocks of setup, then STROBE_CYC clocks with its strobe low, then HOLD_CYC clocks of hold. The defaults are 2, 3 and 2. The busy flag is set for the whole cycle.
- R5: A write to any offset from 0x000 to 0x7FF sends its byte to the flash as one write cycle.
- R6: A read of any offset from 0x000 to 0x7FF runs one read-strobe cycle. The response valid pulse comes when the cycle ends. It carries the byte on the I/O lines at the last strobe-low clock.
- R7: Data-window or byte-port accesses made while the busy flag is set are dropped. They start no flash cycle and get no response.
- R8: The status register is at offset 0x810. Bit 3 is the synchronized ready line (1 = ready), bit 2 is busy, bit 1 is command complete, and bits 7:4 and bit 0 read 0.
- R9: Command complete is set only when the ready line rises after a byte-port cycle that ran with CLE high. A byte-port cycle with CLE low does not set it. A status read clears it.
- R10: Reads of the control register, the status register and unused offsets get a response one clock later, even while busy. Unused offsets return 0.
- R11: The ECC tap pulses for one clock at the end of each data-window cycle and carries that byte. Byte-port cycles do not pulse it.
- R12: The I/O output enable is high only during write cycles and never while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address |
| wr_i | input | 1 | Write strobe, one clock per access |
| rd_i | input | 1 | Read strobe, one clock per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read response valid |
| nand_io_i | input | 8 | Flash I/O lines, input side |
| nand_io_o | output | 8 | Flash I/O lines, output side |
| nand_io_oe_o | output | 1 | Output enable for the I/O lines |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_ce_n_o | output | 1 | Chip enable, active low |
| nand_we_n_o | output | 1 | Write strobe, active low |
| nand_re_n_o | output | 1 | Read strobe, active low |
| nand_rb_n_i | input | 1 | Ready/busy line, high = ready |
| ecc_stb_o | output | 1 | Data byte tap strobe |
| ecc_byte_o | output | 8 | Data byte tap value |

## Verification
The bench builds the block with its default parameters: a 12-bit address, a 2048-byte data window and cycle counts of 2, 3 and 2. With these values it can measure the setup and strobe widths exactly. It can also issue status reads and a dropped access inside the seven busy clocks. The narrow address lets random offsets cover every alias of the register window, and both ends of the data window.

// File: rtl/nand_host_pkg.sv
package nand_host_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;
  typedef enum logic [2:0] {SEL_NONE, SEL_DATA, SEL_CTL, SEL_BYTE, SEL_STAT} sel_e;
  localparam int CTL_W = 5;
  localparam logic [CTL_W-1:0] CTL_RESET = 5'h01;
endpackage

// File: rtl/nand_addr_decode.sv
module nand_addr_decode
  import nand_host_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_SPAN = 2048
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              sel_o
);
  localparam logic [ADDR_W-5:0] REG_BLK   = (ADDR_W-4)'(DATA_SPAN / 16);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(DATA_SPAN + 16);
  localparam logic [ADDR_W-1:0] SPAN_A    = ADDR_W'(DATA_SPAN);

  always_comb begin
    if (addr_i < SPAN_A)                        sel_o = SEL_DATA;
    else if (addr_i[ADDR_W-1:4] == REG_BLK)     sel_o = addr_i[0] ? SEL_BYTE : SEL_CTL;
    else if (addr_i == STAT_ADDR)               sel_o = SEL_STAT;
    else                                        sel_o = SEL_NONE;
  end
endmodule

// File: rtl/nand_cycle_engine.sv
module nand_cycle_engine
  import nand_host_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       is_read_i,
  input  logic [1:0] tag_i,
  input  logic [7:0] wbyte_i,
  input  logic [7:0] io_i,
  output logic       busy_o,
  output logic       we_n_o,
  output logic       re_n_o,
  output logic       oe_o,
  output logic [7:0] byte_o,
  output logic       done_o,
  output logic       done_rd_o,
  output logic [1:0] tag_o
);
  localparam int MAX_AB = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_C  = (MAX_AB > HOLD_CYC) ? MAX_AB : HOLD_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rd_q, done_q;
  logic [1:0]       tag_q;
  logic [7:0]       byte_q;
  logic             last;

  assign last = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      rd_q   <= 1'b0;
      done_q <= 1'b0;
      tag_q  <= '0;
      byte_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q   <= PH_SETUP;
          cnt_q  <= CNT_W'(SETUP_CYC - 1);
          rd_q   <= is_read_i;
          tag_q  <= tag_i;
          byte_q <= wbyte_i;
        end
        PH_SETUP: if (last) begin
          ph_q  <= PH_STROBE;
          cnt_q <= CNT_W'(STROBE_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        PH_STROBE: if (last) begin
          ph_q  <= PH_HOLD;
          cnt_q <= CNT_W'(HOLD_CYC - 1);
          if (rd_q) byte_q <= io_i;   // sample just before the strobe rises
        end else cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (last) begin
          ph_q   <= PH_IDLE;
          done_q <= 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o    = (ph_q != PH_IDLE);
  assign we_n_o    = !((ph_q == PH_STROBE) && !rd_q);
  assign re_n_o    = !((ph_q == PH_STROBE) && rd_q);
  assign oe_o      = busy_o && !rd_q;
  assign byte_o    = byte_q;
  assign done_o    = done_q;
  assign done_rd_o = done_q && rd_q;
  assign tag_o     = tag_q;
endmodule

// File: rtl/nand_status_unit.sv
module nand_status_unit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rb_n_i,
  input  logic arm_i,
  input  logic stat_rd_i,
  output logic ready_o,
  output logic cmd_done_o
);
  logic meta_q, sync_q, prev_q, pend_q, done_q;
  logic rise;

  assign rise = sync_q && !prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      meta_q <= rb_n_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
      if (arm_i)              pend_q <= 1'b1;
      else if (pend_q && rise) pend_q <= 1'b0;
      if (pend_q && rise)     done_q <= 1'b1;
      else if (stat_rd_i)     done_q <= 1'b0;
    end
  end

  assign ready_o    = sync_q;
  assign cmd_done_o = done_q;
endmodule

// File: rtl/nand_mmio_host.sv
module nand_mmio_host
  import nand_host_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_SPAN  = 2048,
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              rvalid_o,
  input  logic [7:0]        nand_io_i,
  output logic [7:0]        nand_io_o,
  output logic              nand_io_oe_o,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_ce_n_o,
  output logic              nand_we_n_o,
  output logic              nand_re_n_o,
  input  logic              nand_rb_n_i,
  output logic              ecc_stb_o,
  output logic [7:0]        ecc_byte_o
);
  sel_e             sel;
  logic [CTL_W-1:0] ctl_q;
  logic             rd_req, cyc_busy, cyc_start, cyc_done, cyc_done_rd;
  logic [1:0]       tag_in, tag_out;
  logic [7:0]       cyc_byte, rsp_q;
  logic             rsp_v_q, stat_rd, rdy, cmd_done;
  logic [7:0]       reg_mux;

  nand_addr_decode #(.ADDR_W(ADDR_W), .DATA_SPAN(DATA_SPAN)) u_dec (
    .addr_i(addr_i), .sel_o(sel)
  );

  assign rd_req    = rd_i && !wr_i;
  assign cyc_start = !cyc_busy &&
                     ((wr_i && (sel == SEL_DATA || sel == SEL_BYTE)) ||
                      (rd_req && sel == SEL_DATA));
  // tag: [1] data window, [0] CLE level at launch
  assign tag_in    = {sel == SEL_DATA, ctl_q[1]};

  nand_cycle_engine #(
    .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(cyc_start), .is_read_i(rd_req),
    .tag_i(tag_in), .wbyte_i(wdata_i), .io_i(nand_io_i), .busy_o(cyc_busy),
    .we_n_o(nand_we_n_o), .re_n_o(nand_re_n_o), .oe_o(nand_io_oe_o),
    .byte_o(cyc_byte), .done_o(cyc_done), .done_rd_o(cyc_done_rd), .tag_o(tag_out)
  );

  assign stat_rd = rd_req && (sel == SEL_STAT);

  nand_status_unit u_sts (
    .clk_i(clk_i), .rst_ni(rst_ni), .rb_n_i(nand_rb_n_i),
    .arm_i(cyc_done && !tag_out[1] && tag_out[0]),
    .stat_rd_i(stat_rd), .ready_o(rdy), .cmd_done_o(cmd_done)
  );

  always_comb begin
    unique case (sel)
      SEL_CTL:  reg_mux = {{(8-CTL_W){1'b0}}, ctl_q};
      SEL_STAT: reg_mux = {4'b0, rdy, cyc_busy, cmd_done, 1'b0};
      default:  reg_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= CTL_RESET;
      rsp_q   <= '0;
      rsp_v_q <= 1'b0;
    end else begin
      if (wr_i && sel == SEL_CTL) ctl_q <= wdata_i[CTL_W-1:0];
      rsp_v_q <= rd_req && (sel != SEL_DATA);
      if (rd_req && sel != SEL_DATA) rsp_q <= reg_mux;
    end
  end

  // a finishing data read takes the response slot over a register read
  assign rvalid_o    = rsp_v_q || cyc_done_rd;
  assign rdata_o     = cyc_done_rd ? cyc_byte : rsp_q;
  assign nand_io_o   = cyc_byte;
  assign nand_ce_n_o = ctl_q[0];
  assign nand_cle_o  = ctl_q[1];
  assign nand_ale_o  = ctl_q[2];
  assign ecc_stb_o   = cyc_done && tag_out[1];
  assign ecc_byte_o  = cyc_byte;
endmodule

// File: rtl/nand_mmio_host_chk.sv
module nand_mmio_host_chk #(
  parameter int ADDR_W    = 12,
  parameter int DATA_SPAN = 2048
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [7:0]        wdata_i,
  input logic              we_n,
  input logic              re_n,
  input logic              oe,
  input logic [7:0]        io_o,
  input logic              ce_n,
  input logic              ecc_stb,
  input logic              busy
);
  localparam logic [ADDR_W-5:0] REG_BLK = (ADDR_W-4)'(DATA_SPAN / 16);

  p_strobe_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_n && !re_n));

  p_strobe_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_n) |-> $past(busy));

  p_no_drive_read_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_n |-> !oe);

  p_io_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_n && $past(!we_n)) |-> $stable(io_o));

  p_ecc_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_stb |=> !ecc_stb);

  p_ce_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[ADDR_W-1:4] == REG_BLK && !addr_i[0]) |=> ce_n == $past(wdata_i[0]));
endmodule

bind nand_mmio_host nand_mmio_host_chk #(.ADDR_W(ADDR_W), .DATA_SPAN(DATA_SPAN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i),
  .we_n(nand_we_n_o), .re_n(nand_re_n_o), .oe(nand_io_oe_o), .io_o(nand_io_o),
  .ce_n(nand_ce_n_o), .ecc_stb(ecc_stb_o), .busy(cyc_busy)
);

// File: tb/nand_mmio_host_tb_top.sv
module nand_mmio_host_tb_top;
  localparam int S = 2, T = 3, H = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o, nand_io_i, nand_io_o, ecc_byte_o;
  logic rvalid_o, nand_io_oe_o, nand_cle_o, nand_ale_o, nand_ce_n_o;
  logic nand_we_n_o, nand_re_n_o, ecc_stb_o;
  logic nand_rb_n_i = 1'b1;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  nand_mmio_host dut_i (.*);

  // flash model
  int rd_k = 0;
  function automatic logic [7:0] mdl(int k);
    return 8'(k * 37 + 90);
  endfunction
  assign nand_io_i = nand_re_n_o ? 8'h00 : mdl(rd_k);
  always @(posedge nand_re_n_o) if (rst_ni) rd_k++;

  logic [7:0] log_b [256]; logic log_c [256]; logic log_a [256]; int log_n = 0;
  logic [7:0] exp_b [256]; logic exp_c [256]; logic exp_a [256]; int exp_n = 0;
  logic [7:0] ecc_got [256]; logic [7:0] ecc_exp [256]; int ecc_gn = 0, ecc_en = 0;
  int bad_oe = 0;

  always @(posedge nand_we_n_o) if (rst_ni && log_n < 256) begin
    log_b[log_n] = nand_io_o; log_c[log_n] = nand_cle_o; log_a[log_n] = nand_ale_o; log_n++;
  end
  always @(negedge clk_i) if (rst_ni) begin
    if (ecc_stb_o && ecc_gn < 256) begin ecc_got[ecc_gn] = ecc_byte_o; ecc_gn++; end
    if (!nand_re_n_o && nand_io_oe_o) bad_oe++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push_flash(input logic [7:0] b, input logic c, input logic a);
    exp_b[exp_n] = b; exp_c[exp_n] = c; exp_a[exp_n] = a; exp_n++;
  endtask
  task automatic push_ecc(input logic [7:0] b);
    ecc_exp[ecc_en] = b; ecc_en++;
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [7:0] d, output bit ok);
    int n;
    @(negedge clk_i); addr_i = a; rd_i = 1'b1;
    @(negedge clk_i); rd_i = 1'b0;
    n = 0;
    while (!rvalid_o && n < 40) begin @(negedge clk_i); n++; end
    ok = rvalid_o; d = rdata_o;
  endtask

  task automatic wait_idle();
    repeat (S + T + H + 2) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d; bit ok; int s, t, re_low;
    logic cc, ca;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // R1 reset state
    chk("R1 ce_n", nand_ce_n_o, 1); chk("R1 cle", nand_cle_o, 0); chk("R1 ale", nand_ale_o, 0);
    chk("R1 strobes", {nand_we_n_o, nand_re_n_o}, 2'b11); chk("R1 oe", nand_io_oe_o, 0);
    bus_rd(12'h800, d, ok); chk("R1 ctl reset", d, 8'h01);
    bus_rd(12'h810, d, ok); chk("R8 status idle", d, 8'h08);

    // R2 control register aliases
    bus_wr(12'h80E, 8'h1A);
    @(negedge clk_i);
    chk("R2 ce_n", nand_ce_n_o, 0); chk("R2 cle", nand_cle_o, 1); chk("R2 ale", nand_ale_o, 0);
    bus_rd(12'h804, d, ok); chk("R2 readback", d, 8'h1A);
    bus_wr(12'h802, 8'h04);

    // R3 R4 byte port timing with ALE
    bus_wr(12'h80F, 8'h3C);
    s = 0; while (nand_we_n_o && s < 20) begin @(negedge clk_i); s++; end
    chk("R12 oe during write", nand_io_oe_o, 1);
    chk("R3 io during strobe", nand_io_o, 8'h3C);
    t = 0; while (!nand_we_n_o && t < 20) begin @(negedge clk_i); t++; end
    chk("R4 setup clocks", s, S); chk("R4 strobe clocks", t, T);
    push_flash(8'h3C, 0, 1);
    wait_idle();

    // R4 busy, R10 read while busy, R7 dropped write
    bus_wr(12'h801, 8'h11); push_flash(8'h11, 0, 1);
    bus_rd(12'h810, d, ok); chk("R10 status while busy valid", ok, 1);
    chk("R4 busy set", d[2], 1);
    bus_wr(12'h000, 8'h99);
    wait_idle();
    bus_rd(12'h810, d, ok); chk("R4 busy cleared", d[2], 0);
    chk("R7 dropped write", log_n, exp_n);

    // R5 top of window, R7 dropped read
    bus_wr(12'h7FF, 8'h55); push_flash(8'h55, 0, 1); push_ecc(8'h55);
    bus_rd(12'h123, d, ok); chk("R7 dropped read response", ok, 0);
    wait_idle();

    // R6 data read
    re_low = rd_k;
    bus_rd(12'h000, d, ok); chk("R6 read valid", ok, 1); chk("R6 read byte", d, mdl(re_low));
    push_ecc(mdl(re_low));
    wait_idle();

    // R9 negative: address byte does not arm
    bus_wr(12'h800, 8'h04);
    bus_wr(12'h805, 8'hA0); push_flash(8'hA0, 0, 1); wait_idle();
    nand_rb_n_i = 1'b0; repeat (5) @(negedge clk_i);
    nand_rb_n_i = 1'b1; repeat (5) @(negedge clk_i);
    bus_rd(12'h810, d, ok); chk("R9 no arm on address", d[1], 0);

    // R9 positive
    bus_wr(12'h806, 8'h02);
    bus_wr(12'h803, 8'h70); push_flash(8'h70, 1, 0); wait_idle();
    bus_rd(12'h810, d, ok); chk("R9 not before rise", d, 8'h08);
    nand_rb_n_i = 1'b0; repeat (5) @(negedge clk_i);
    bus_rd(12'h810, d, ok); chk("R8 flash busy", d, 8'h00);
    nand_rb_n_i = 1'b1; repeat (5) @(negedge clk_i);
    bus_rd(12'h810, d, ok); chk("R9 complete set", d, 8'h0A);
    bus_rd(12'h810, d, ok); chk("R9 cleared by read", d, 8'h08);

    // R10 unused offset
    bus_rd(12'h900, d, ok); chk("R10 unused valid", ok, 1); chk("R10 unused data", d, 0);

    // random mix
    bus_wr(12'h800, 8'h00); cc = 0; ca = 0;
    for (int i = 0; i < 80; i++) begin
      int op; logic [7:0] v;
      op = $urandom % 4; v = 8'($urandom);
      case (op)
        0: begin
          v = v & 8'h06;
          bus_wr(12'h800 + 12'(2 * ($urandom % 8)), v); cc = v[1]; ca = v[2];
        end
        1: begin bus_wr(12'h801 + 12'(2 * ($urandom % 8)), v); push_flash(v, cc, ca); end
        2: begin bus_wr(12'($urandom % 2048), v); push_flash(v, cc, ca); push_ecc(v); end
        default: begin
          int k; k = rd_k;
          bus_rd(12'($urandom % 2048), d, ok);
          chk("R6 random read", d, mdl(k)); push_ecc(mdl(k));
        end
      endcase
      wait_idle();
    end

    // R3 R5 flash log, R11 ECC tap, R12 oe
    chk("R5 flash write count", log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      chk("R3 logged byte", log_b[i], exp_b[i]);
      chk("R3 logged latches", {log_c[i], log_a[i]}, {exp_c[i], exp_a[i]});
    end
    chk("R11 tap count", ecc_gn, ecc_en);
    for (int i = 0; i < ecc_en && i < ecc_gn; i++) chk("R11 tap byte", ecc_got[i], ecc_exp[i]);
    chk("R12 oe while reading", bad_oe, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule